// File: doc/BRIEF.md
# FPU Stage Reservation Hazard Unit

This block decides whether a floating-point or integer-multiply instruction can start in the current cycle without colliding with work that is already in flight. It keeps a table of future resource use, one row per upcoming cycle. The resources are four floating-point stage positions (F0 to F3), a decode lock, and two multiply sub-units (A and B) that share the F1 position.

Each instruction class has a fixed reservation pattern that spans up to 24 cycles. The issue logic presents a class code with a valid strobe. In the same cycle the block answers accept or conflict. An accepted pattern is merged into the table at the clock edge. The table moves forward by one cycle on every clock. No arithmetic is done here.

Top module: `fpu_resv_hazard`

## Requirements
- R1: When valid_i is low, or cls_i is 7 (no class), accept_o and conflict_o are both low and no resource is reserved.
- R2: For cls_i 0..6 with valid_i high, exactly one of accept_o or conflict_o is high in the same cycle. Accept is given only if no cycle of the pattern overlaps the table. A rejected pattern reserves nothing. The table advances one cycle per clock. Offset k of a pattern presented now lines up with offset k+g of a pattern accepted g cycles earlier.
- R3: Class 0 (single arithmetic) reserves F0+F1 at offset 1 and F2 at offset 2.
- R4: Class 1 (single divide) reserves the following:
  - F0+F1+F3 at offset 1.
  - F2+F3 at offset 2.
  - F3 at offsets 3..9.
  - F1+F3 at offset 10.
  - F2 at offset 11.
- R5: Class 2 (double add/multiply) reserves F0+F1 at offset 1, F1+F2 at offsets 2..6, and F2 at offset 7.
- R6: Class 3 (double divide) reserves the following:
  - F0+F1+F3 at offset 1.
  - F1+F2+F3 at offset 2.
  - F2+F3 at offset 3.
  - F3 at offsets 4..19.
  - F1+F3 at offset 20.
  - F1+F2+F3 at offsets 21..22.
  - F2 at offset 23.
- R7: Class 4 (integer multiply) reserves the following:
  - The decode lock at offset 0.
  - The decode lock and sub-unit A at offset 1.
  - One sub-unit at each of offsets 2..4: A when A is free, otherwise B.
  - F2 at offset 5.
- R8: In any cycle, F1 and a multiply sub-unit are never both reserved. A request for one clashes with the table holding the other.
- R9: Class 5 (status register load) reserves the decode lock at offset 0 and F1 at offsets 2..4.
- R10: Class 6 (double conversion) reserves F0+F1 at offset 1, F1+F2 at offset 2, and F2 at offset 3.
- R11: Reset empties the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction class is presented this cycle |
| cls_i | input | 3 | Instruction class code (0..6, 7 = none) |
| accept_o | output | 1 | Pattern fits; it is committed at this clock edge |
| conflict_o | output | 1 | Pattern overlaps the table; nothing is committed |

## Verification
Accept and conflict are combinational. They are due in the same cycle that the class is presented. The bench drives each request just after the falling edge and samples a few nanoseconds later, before the rising edge that commits it. A committed reservation affects a request made g cycles later at offset k exactly when it sits at offset k+g of the earlier pattern. For each class, the bench probes the last gap that must still clash and the first gap that must pass, and sets each gap with idle cycles counted from the commit edge.

// File: rtl/fpu_resv_pkg.sv
package fpu_resv_pkg;
  localparam int NRES = 7;
  localparam int B_D  = 0;
  localparam int B_F0 = 1;
  localparam int B_F1 = 2;
  localparam int B_F2 = 3;
  localparam int B_F3 = 4;
  localparam int B_MA = 5;
  localparam int B_MB = 6;

  typedef logic [NRES-1:0] res_t;

  localparam res_t M_D  = res_t'(1) << B_D;
  localparam res_t M_F0 = res_t'(1) << B_F0;
  localparam res_t M_F1 = res_t'(1) << B_F1;
  localparam res_t M_F2 = res_t'(1) << B_F2;
  localparam res_t M_F3 = res_t'(1) << B_F3;
  localparam res_t M_MA = res_t'(1) << B_MA;

  typedef enum logic [2:0] {
    CL_SP_ARITH = 3'd0,
    CL_SP_DIV   = 3'd1,
    CL_DP_ARITH = 3'd2,
    CL_DP_DIV   = 3'd3,
    CL_IMUL     = 3'd4,
    CL_STAT_LD  = 3'd5,
    CL_DP_CONV  = 3'd6,
    CL_NONE     = 3'd7
  } cls_e;

  // fixed resources of class c at offset k
  function automatic res_t slot_res(cls_e c, int k);
    res_t r = '0;
    unique case (c)
      CL_SP_ARITH: begin
        if (k == 1) r = M_F0 | M_F1;
        else if (k == 2) r = M_F2;
      end
      CL_SP_DIV: begin
        if (k == 1) r = M_F0 | M_F1 | M_F3;
        else if (k == 2) r = M_F2 | M_F3;
        else if (k >= 3 && k <= 9) r = M_F3;
        else if (k == 10) r = M_F1 | M_F3;
        else if (k == 11) r = M_F2;
      end
      CL_DP_ARITH: begin
        if (k == 1) r = M_F0 | M_F1;
        else if (k >= 2 && k <= 6) r = M_F1 | M_F2;
        else if (k == 7) r = M_F2;
      end
      CL_DP_DIV: begin
        if (k == 1) r = M_F0 | M_F1 | M_F3;
        else if (k == 2) r = M_F1 | M_F2 | M_F3;
        else if (k == 3) r = M_F2 | M_F3;
        else if (k >= 4 && k <= 19) r = M_F3;
        else if (k == 20) r = M_F1 | M_F3;
        else if (k == 21 || k == 22) r = M_F1 | M_F2 | M_F3;
        else if (k == 23) r = M_F2;
      end
      CL_IMUL: begin
        if (k == 0) r = M_D;
        else if (k == 1) r = M_D | M_MA;
        else if (k == 5) r = M_F2;
      end
      CL_STAT_LD: begin
        if (k == 0) r = M_D;
        else if (k >= 2 && k <= 4) r = M_F1;
      end
      CL_DP_CONV: begin
        if (k == 1) r = M_F0 | M_F1;
        else if (k == 2) r = M_F1 | M_F2;
        else if (k == 3) r = M_F2;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // offsets where one of the two multiply sub-units is needed
  function automatic logic slot_flex(cls_e c, int k);
    return (c == CL_IMUL) && (k >= 2) && (k <= 4);
  endfunction
endpackage

// File: rtl/fpu_resv_pattern.sv
module fpu_resv_pattern
  import fpu_resv_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic [2:0]                 cls_i,
  output logic [DEPTH-1:0][NRES-1:0] base_o,
  output logic [DEPTH-1:0]           flex_o
);
  cls_e cls;
  assign cls = cls_e'(cls_i);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign base_o[k] = slot_res(cls, k);
    assign flex_o[k] = slot_flex(cls, k);
  end
endmodule

// File: rtl/fpu_resv_check.sv
module fpu_resv_check
  import fpu_resv_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic [DEPTH-1:0][NRES-1:0] base_i,
  input  logic [DEPTH-1:0]           flex_i,
  input  logic [DEPTH-1:0][NRES-1:0] occ_i,
  output logic [DEPTH-1:0][NRES-1:0] req_o,
  output logic                       clash_o
);
  logic [DEPTH-1:0] bad;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cyc
    logic [NRES-1:0] r;
    logic            b;
    always_comb begin
      r = base_i[k];
      b = 1'b0;
      if (flex_i[k]) begin
        if (occ_i[k][B_F1])      b = 1'b1;
        else if (!occ_i[k][B_MA]) r[B_MA] = 1'b1;
        else if (!occ_i[k][B_MB]) r[B_MB] = 1'b1;
        else                      b = 1'b1;
      end
      if (|(r & occ_i[k])) b = 1'b1;
      // multiply sub-units exclude F1 in the same cycle
      if (r[B_F1] && (occ_i[k][B_MA] || occ_i[k][B_MB])) b = 1'b1;
      if ((r[B_MA] || r[B_MB]) && occ_i[k][B_F1]) b = 1'b1;
    end
    assign req_o[k] = r;
    assign bad[k]   = b;
  end

  assign clash_o = |bad;
endmodule

// File: rtl/fpu_resv_table.sv
module fpu_resv_table
  import fpu_resv_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [DEPTH-1:1][NRES-1:0] req_i,
  output logic [DEPTH-1:0][NRES-1:0] occ_o
);
  logic [DEPTH-1:0][NRES-1:0] occ_q;

  // entry k holds use k cycles ahead; offset 0 of a request is spent now
  for (genvar k = 0; k < DEPTH; k++) begin : g_row
    if (k == DEPTH-1) begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) occ_q[k] <= '0;
        else         occ_q[k] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) occ_q[k] <= '0;
        else         occ_q[k] <= occ_q[k+1] | (commit_i ? req_i[k+1] : '0);
      end
    end
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/fpu_resv_hazard.sv
module fpu_resv_hazard
  import fpu_resv_pkg::*;
#(
  parameter int DEPTH = 32  // must exceed the longest pattern (24)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [2:0] cls_i,
  output logic       accept_o,
  output logic       conflict_o
);
  logic [DEPTH-1:0][NRES-1:0] base;
  logic [DEPTH-1:0]           flex;
  logic [DEPTH-1:0][NRES-1:0] req;
  logic [DEPTH-1:0][NRES-1:0] occ;
  logic                       clash;
  logic                       known;
  logic [NRES-1:0]            occ_now;

  fpu_resv_pattern #(.DEPTH(DEPTH)) u_pattern (
    .cls_i  (cls_i),
    .base_o (base),
    .flex_o (flex)
  );

  fpu_resv_check #(.DEPTH(DEPTH)) u_check (
    .base_i  (base),
    .flex_i  (flex),
    .occ_i   (occ),
    .req_o   (req),
    .clash_o (clash)
  );

  fpu_resv_table #(.DEPTH(DEPTH)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (accept_o),
    .req_i    (req[DEPTH-1:1]),
    .occ_o    (occ)
  );

  assign known      = (cls_i != CL_NONE);
  assign accept_o   = valid_i && known && !clash;
  assign conflict_o = valid_i && known && clash;
  assign occ_now    = occ[0];
endmodule

// File: rtl/fpu_resv_hazard_chk.sv
module fpu_resv_hazard_chk
  import fpu_resv_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [2:0]      cls_i,
  input logic            accept_o,
  input logic            conflict_o,
  input logic [NRES-1:0] occ_now_i
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || cls_i == 3'd7) |-> (!accept_o && !conflict_o));

  p_one_answer_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls_i != 3'd7) |-> (accept_o ^ conflict_o));

  p_dlock_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && cls_i == 3'd4) |=> (occ_now_i[B_D] && occ_now_i[B_MA]));

  p_mul_f1_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(occ_now_i[B_F1] && (occ_now_i[B_MA] || occ_now_i[B_MB])));

  p_sp_arith_f1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && cls_i == 3'd0) |=> (occ_now_i[B_F0] && occ_now_i[B_F1]));
endmodule

bind fpu_resv_hazard fpu_resv_hazard_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .cls_i      (cls_i),
  .accept_o   (accept_o),
  .conflict_o (conflict_o),
  .occ_now_i  (occ_now)
);

// File: tb/fpu_resv_hazard_bench.sv
`timescale 1ns/1ps
module fpu_resv_hazard_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] cls_i = 3'd7;
  logic       accept_o, conflict_o;
  int         n_chk = 0;
  int         n_bad = 0;

  localparam logic [2:0] SPA = 3'd0, SPD = 3'd1, DPA = 3'd2, DPD = 3'd3,
                         MUL = 3'd4, STL = 3'd5, CNV = 3'd6, NON = 3'd7;

  always #10 clk_i = ~clk_i;

  fpu_resv_hazard u_fpu_resv_hazard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .cls_i      (cls_i),
    .accept_o   (accept_o),
    .conflict_o (conflict_o)
  );

  task automatic check(input logic ea, input logic ec, input string tag);
    n_chk++;
    if (accept_o !== ea || conflict_o !== ec) begin
      n_bad++;
      $display("FAIL %s: acc/con = %b%b, expected %b%b", tag, accept_o, conflict_o, ea, ec);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; valid_i = 1'b0; cls_i = NON;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  // one request cycle; the next try follows one cycle later
  task automatic try_cls(input logic [2:0] c, input logic v, input logic ea,
                         input logic ec, input string tag);
    @(negedge clk_i);
    valid_i = v; cls_i = c;
    #3 check(ea, ec, tag);
    @(posedge clk_i);
    #1 valid_i = 1'b0; cls_i = NON;
  endtask

  // gap g between requests: idle(g-1)
  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic t_reset();
    do_reset();
    #3 check(1'b0, 1'b0, "R1 idle after reset");
    try_cls(DPD, 1'b1, 1'b1, 1'b0, "R6 first dp divide");
    do_reset();
    try_cls(SPD, 1'b1, 1'b1, 1'b0, "R11 reset empties table");
  endtask

  task automatic t_ignored();
    do_reset();
    try_cls(SPD, 1'b0, 1'b0, 1'b0, "R1 valid low");
    try_cls(SPD, 1'b1, 1'b1, 1'b0, "R1 valid low reserved nothing");
    try_cls(NON, 1'b1, 1'b0, 1'b0, "R1 code 7 gives no answer");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R1 code 7 reserved nothing");
  endtask

  task automatic t_sp_arith();
    do_reset();
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R3 arith 1");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R3 arith 2 pipelined");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R3 arith 3 pipelined");
  endtask

  task automatic t_dp_arith();
    do_reset();
    try_cls(DPA, 1'b1, 1'b1, 1'b0, "R5 dp arith");
    idle(3);
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R5 gap4 F1 busy");
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R5 gap5 F1 busy");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R5 gap6 free");
  endtask

  task automatic t_sp_div();
    do_reset();
    try_cls(SPD, 1'b1, 1'b1, 1'b0, "R4 div");
    idle(7);
    try_cls(SPD, 1'b1, 1'b0, 1'b1, "R4 gap8 F3 busy");
    try_cls(SPD, 1'b1, 1'b0, 1'b1, "R4 gap9 F1+F3 busy");
    try_cls(SPD, 1'b1, 1'b1, 1'b0, "R2 gap10 rejected left no trace");
  endtask

  task automatic t_dp_div();
    do_reset();
    try_cls(DPD, 1'b1, 1'b1, 1'b0, "R6 dp divide");
    idle(19);
    try_cls(SPD, 1'b1, 1'b0, 1'b1, "R6 gap20 F3 busy");
    try_cls(SPD, 1'b1, 1'b0, 1'b1, "R6 gap21 F3 busy");
    try_cls(SPD, 1'b1, 1'b1, 1'b0, "R6 gap22 free");
  endtask

  task automatic t_imul();
    do_reset();
    try_cls(MUL, 1'b1, 1'b1, 1'b0, "R7 multiply");
    try_cls(MUL, 1'b1, 1'b0, 1'b1, "R7 gap1 decode lock");
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R8 gap2 F1 vs sub-unit");
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R8 gap3 F1 vs sub-unit");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R7 gap4 free");
  endtask

  task automatic t_stat_ld();
    do_reset();
    try_cls(STL, 1'b1, 1'b1, 1'b0, "R9 status load");
    try_cls(MUL, 1'b1, 1'b0, 1'b1, "R8 gap1 sub-unit vs F1");
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R9 gap2 F1 busy");
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R9 gap3 F1 busy");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R9 gap4 free");
    try_cls(MUL, 1'b1, 1'b1, 1'b0, "R8 multiply beside arith");
  endtask

  task automatic t_conv();
    do_reset();
    try_cls(CNV, 1'b1, 1'b1, 1'b0, "R10 conversion");
    try_cls(SPA, 1'b1, 1'b0, 1'b1, "R10 gap1 F1 busy");
    try_cls(SPA, 1'b1, 1'b1, 1'b0, "R10 gap2 free");
  endtask

  initial begin
    t_reset();
    t_ignored();
    t_sp_arith();
    t_dp_arith();
    t_sp_div();
    t_dp_div();
    t_imul();
    t_stat_ld();
    t_conv();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule